// File: doc/BRIEF.md
# Ethernet PHY LED Behaviour Controller

This block drives four indicator LEDs for an Ethernet PHY from a small bank of configuration registers and a set of PHY status inputs. Each LED has four independent sources: a steady-on condition, a fast-blink condition, a slow-blink condition and an activity pulse mask. A condition is a 4-bit code that names a set of link speeds or one of the PHY's busy or low-power states. The two blink rates are shared by all LEDs and are programmable. Both blink waves come from dividers driven by a 1 kHz tick input.

Software programs the behaviour through a plain address/data port with a write enable and a combinational read-back. The LED outputs are registered, so a status change shows on the pins one clock after it is sampled.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset the ten registers at 0x1E0..0x1E9 read 0x00C5, 0x0067, 0x0070, 0x0003, 0x0020, 0x0000, 0x0040, 0x0000, 0x0040, 0x0020. Both blink waves start low, and all LEDs are dark while the link is down and every status input is low.
- R2: A write with `cfg_we` high stores `cfg_wdata[7:0]`. Read-back bits 15:8 are always zero. An address outside 0x1E0..0x1E9 reads zero, and a write to it changes no register.
- R3: Condition codes 1..7 form a speed set: bit0 is 10, bit1 is 100 and bit2 is 1000 Mbit/s. The code is true only while `link_up` is high and `link_speed` (0=10, 1=100, 2=1000, 3=none) is a member of the set.
- R4: Code 0 is never true. Code 8 follows power-down, 9 follows EEE, 0xA follows auto-negotiation, 0xB follows self-test and 0xC follows cable diagnostics. Codes 0xD..0xF are never true.
- R5: With no pulse and no blink condition true, an LED equals its steady-on condition. The steady field is bits 7:4 of the LED's first register.
- R6: The fast rate sits in global-high bits 7:6. The fast wave changes level every 250>>code ticks (codes 0..3 give 2/4/8/16 Hz), and it changes only on a tick.
- R7: The slow rate sits in global-high bits 5:4. The slow wave changes level every 250>>code ticks.
- R8: For each LED, a true fast condition (bits 3:0 of its first register) shows the fast wave. Otherwise a true slow condition (bits 7:4 of its second register) shows the slow wave. Otherwise the steady condition applies.
- R9: The pulse mask sits in bits 3:0 of the LED's second register: bit0 transmit, bit1 receive, bit2 collision, bit3 reserved. A masked event holds the LED dark for 30 ticks, and an event during the hold restarts the 30. Unmasked events and bit3 have no effect.
- R10: The global-low register and global-high bits 2:0 are stored and read back but do not change any LED.
- R11: A change on a status input reaches `led_o` at the next clock edge, not combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 16 | Register address |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0=10, 1=100, 2=1000 Mbit/s, 3=none |
| pwr_down | input | 1 | PHY powered down |
| eee_active | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cdiag_busy | input | 1 | Cable diagnostics running |
| tx_act | input | 1 | Transmit activity event |
| rx_act | input | 1 | Receive activity event |
| col_det | input | 1 | Collision event |
| led_o | output | 4 | LED drive, high = lit |

## Verification
The assertions check the following on every cycle:
- a stretched pulse always darkens its LED on the next edge;
- a masked event reloads the full hold;
- the hold and divider counters stay within their bounds;
- the blink waves move only on ticks;
- registers stay unchanged without a write;
- reserved read-back bits stay zero.

Only the bench scenarios can show the following:
- the exact tick count between blink edges for each rate code;
- the decoding of every condition code against the status inputs;
- the fast-over-slow-over-steady priority;
- the 30-tick hold and its restart;
- the register reset values and out-of-range handling.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

    localparam int REG_W    = 16;
    localparam int FIELD_W  = 8;
    localparam int NUM_LEDS = 4;
    localparam int NUM_REGS = 2 + 2 * NUM_LEDS;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_NONE = 2'd3
    } speed_e;

    typedef struct packed {
        logic   link_up;
        speed_e speed;
        logic   pwr_down;
        logic   eee;
        logic   aneg;
        logic   selftest;
        logic   cdiag;
    } phy_state_t;

    typedef struct packed {
        logic [3:0] steady;
        logic [3:0] fast;
        logic [3:0] slow;
        logic [3:0] pmask;
    } led_cfg_t;

    typedef struct packed {
        logic [1:0] fast_rate;
        logic [1:0] slow_rate;
    } blink_cfg_t;

    function automatic logic cond_hit(logic [3:0] code, phy_state_t st);
        logic in_set;
        unique case (st.speed)
            SPD_10:   in_set = code[0];
            SPD_100:  in_set = code[1];
            SPD_1000: in_set = code[2];
            default:  in_set = 1'b0;
        endcase
        case (code)
            4'h1, 4'h2, 4'h3, 4'h4,
            4'h5, 4'h6, 4'h7: return st.link_up && in_set;
            4'h8:             return st.pwr_down;
            4'h9:             return st.eee;
            4'hA:             return st.aneg;
            4'hB:             return st.selftest;
            4'hC:             return st.cdiag;
            default:          return 1'b0;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] reg_reset_val(int idx);
        case (idx)
            0:       return 8'hC5;
            1:       return 8'h67;
            2:       return 8'h70;
            3:       return 8'h03;
            4:       return 8'h20;
            6:       return 8'h40;
            8:       return 8'h40;
            9:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import led_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h1E0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [REG_W-1:0]           wdata,
    output logic [REG_W-1:0]           rdata,
    output blink_cfg_t                 blink_cfg,
    output led_cfg_t [NUM_LEDS-1:0]    led_cfg
);

    localparam int IW = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][FIELD_W-1:0] mem;
    logic [ADDR_W-1:0]                offset;
    logic [IW-1:0]                    idx;
    logic                             hit;
    logic                             unused_wdata_hi;

    assign offset          = addr - ADDR_W'(BASE_ADDR);
    assign hit             = (addr >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(NUM_REGS));
    assign idx             = offset[IW-1:0];
    assign unused_wdata_hi = ^wdata[REG_W-1:FIELD_W];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= reg_reset_val(g);
            else if (we && hit && idx == IW'(g))
                mem[g] <= wdata[FIELD_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit)
            rdata[FIELD_W-1:0] = mem[idx];
    end

    assign blink_cfg.fast_rate = mem[0][7:6];
    assign blink_cfg.slow_rate = mem[0][5:4];

    for (genvar l = 0; l < NUM_LEDS; l++) begin : g_map
        assign led_cfg[l].steady = mem[2 + 2*l][7:4];
        assign led_cfg[l].fast   = mem[2 + 2*l][3:0];
        assign led_cfg[l].slow   = mem[3 + 2*l][7:4];
        assign led_cfg[l].pmask  = mem[3 + 2*l][3:0];
    end

    AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem)); // R2
    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[REG_W-1:FIELD_W] == '0); // R2

endmodule

// File: rtl/led_blink_div.sv
module led_blink_div #(
    parameter int HALF_MAX = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] rate,
    output logic       wave
);

    localparam int CW = $clog2(HALF_MAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;

    assign half_m1 = CW'((HALF_MAX >> rate) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (tick) begin
            if (cnt >= half_m1) begin
                cnt  <= '0;
                wave <= ~wave;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(HALF_MAX)); // R6
    AST_WAVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(wave)); // R6

endmodule

// File: rtl/led_lane.sv
module led_lane
    import led_ctrl_pkg::*;
#(
    parameter int STRETCH_TICKS = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  led_cfg_t   cfg,
    input  phy_state_t st,
    input  logic       tx_evt,
    input  logic       rx_evt,
    input  logic       col_evt,
    input  logic       fast_wave,
    input  logic       slow_wave,
    output logic       led
);

    localparam int SW = $clog2(STRETCH_TICKS + 1);

    logic [SW-1:0] hold_cnt;
    logic          evt;
    logic          pulsing;
    logic          steady_hit, fast_hit, slow_hit;
    logic          led_next;
    logic          unused_rsvd_mask;

    assign unused_rsvd_mask = cfg.pmask[3];
    assign evt      = |(cfg.pmask[2:0] & {col_evt, rx_evt, tx_evt});
    assign pulsing  = (hold_cnt != '0);

    assign steady_hit = cond_hit(cfg.steady, st);
    assign fast_hit   = cond_hit(cfg.fast, st);
    assign slow_hit   = cond_hit(cfg.slow, st);

    always_comb begin
        if (pulsing)       led_next = 1'b0;
        else if (fast_hit) led_next = fast_wave;
        else if (slow_hit) led_next = slow_wave;
        else               led_next = steady_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            led      <= 1'b0;
        end else begin
            if (evt)
                hold_cnt <= SW'(STRETCH_TICKS);
            else if (tick && pulsing)
                hold_cnt <= hold_cnt - 1'b1;
            led <= led_next;
        end
    end

    AST_PULSE_DARK: assert property (@(posedge clk) disable iff (rst)
        pulsing |=> !led); // R9
    AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        evt |=> hold_cnt == SW'(STRETCH_TICKS)); // R9
    AST_STRETCH_MAX: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= SW'(STRETCH_TICKS)); // R9
    AST_STEADY_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (!pulsing && !fast_hit && !slow_hit && steady_hit) |=> led); // R5

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
    import led_ctrl_pkg::*;
#(
    parameter int TICK_HZ    = 1000,
    parameter int STRETCH_MS = 30,
    parameter int ADDR_W     = 16,
    parameter int BASE_ADDR  = 'h1E0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_1k,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                link_up,
    input  logic [1:0]          link_speed,
    input  logic                pwr_down,
    input  logic                eee_active,
    input  logic                aneg_busy,
    input  logic                selftest_busy,
    input  logic                cdiag_busy,
    input  logic                tx_act,
    input  logic                rx_act,
    input  logic                col_det,
    output logic [NUM_LEDS-1:0] led_o
);

    localparam int STRETCH_TICKS = STRETCH_MS * TICK_HZ / 1000;
    localparam int HALF_MAX      = TICK_HZ / 4;

    blink_cfg_t               blink_cfg;
    led_cfg_t [NUM_LEDS-1:0]  led_cfg;
    phy_state_t               st;
    logic [1:0]               waves;
    logic [1:0][1:0]          rates;

    assign st.link_up  = link_up;
    assign st.speed    = speed_e'(link_speed);
    assign st.pwr_down = pwr_down;
    assign st.eee      = eee_active;
    assign st.aneg     = aneg_busy;
    assign st.selftest = selftest_busy;
    assign st.cdiag    = cdiag_busy;

    led_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .blink_cfg (blink_cfg),
        .led_cfg   (led_cfg)
    );

    assign rates[0] = blink_cfg.fast_rate;
    assign rates[1] = blink_cfg.slow_rate;

    for (genvar g = 0; g < 2; g++) begin : g_blink
        led_blink_div #(
            .HALF_MAX (HALF_MAX)
        ) u_div (
            .clk  (clk),
            .rst  (rst),
            .tick (tick_1k),
            .rate (rates[g]),
            .wave (waves[g])
        );
    end

    for (genvar l = 0; l < NUM_LEDS; l++) begin : g_lane
        led_lane #(
            .STRETCH_TICKS (STRETCH_TICKS)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick_1k),
            .cfg       (led_cfg[l]),
            .st        (st),
            .tx_evt    (tx_act),
            .rx_evt    (rx_act),
            .col_evt   (col_det),
            .fast_wave (waves[0]),
            .slow_wave (waves[1]),
            .led       (led_o[l])
        );
    end

endmodule

// File: tb/sim_phy_led_ctrl.sv
module sim_phy_led_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1k = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        link_up = 1'b0;
    logic [1:0]  link_speed = 2'd3;
    logic        pwr_down = 1'b0, eee_active = 1'b0, aneg_busy = 1'b0;
    logic        selftest_busy = 1'b0, cdiag_busy = 1'b0;
    logic        tx_act = 1'b0, rx_act = 1'b0, col_det = 1'b0;
    logic [3:0]  led_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    phy_led_ctrl u0 (
        .clk(clk), .rst(rst), .tick_1k(tick_1k),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .link_up(link_up), .link_speed(link_speed), .pwr_down(pwr_down),
        .eee_active(eee_active), .aneg_busy(aneg_busy), .selftest_busy(selftest_busy),
        .cdiag_busy(cdiag_busy), .tx_act(tx_act), .rx_act(rx_act), .col_det(col_det),
        .led_o(led_o)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [15:0] a, logic [15:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic tick_once();
        @(negedge clk); tick_1k = 1'b1;
        @(negedge clk); tick_1k = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        settle(2);
        rst = 1'b0;
        settle(1);
    endtask

    // Condition model from R3/R4
    function automatic logic cond(logic [3:0] c);
        logic in_set;
        in_set = (link_speed == 2'd0) ? c[0] :
                 (link_speed == 2'd1) ? c[1] :
                 (link_speed == 2'd2) ? c[2] : 1'b0;
        if (c >= 4'h1 && c <= 4'h7) return link_up && in_set;
        case (c)
            4'h8: return pwr_down;
            4'h9: return eee_active;
            4'hA: return aneg_busy;
            4'hB: return selftest_busy;
            4'hC: return cdiag_busy;
            default: return 1'b0;
        endcase
    endfunction

    // Ticks between two consecutive level changes of one LED
    task automatic measure(string req, int led, int exp_half);
        logic prev;
        int   n;
        prev = led_o[led];
        for (int i = 0; i < 600; i++) begin
            tick_once(); settle(2);
            if (led_o[led] !== prev) break;
        end
        prev = led_o[led];
        n = 0;
        for (int i = 0; i < 600; i++) begin
            tick_once(); n++; settle(2);
            if (led_o[led] !== prev) break;
        end
        check(req, 16'(n), 16'(exp_half));
    endtask

    initial begin : watchdog
        #(150000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] rv [10];
        logic [7:0]  hi [4];
        logic [7:0]  lo [4];
        logic        e;
        void'($urandom(32'd20240611));
        rv = '{16'h00C5, 16'h0067, 16'h0070, 16'h0003, 16'h0020,
               16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0020};

        settle(3);
        rst = 1'b0;
        settle(2);
        // R1 reset values and dark LEDs
        for (int i = 0; i < 10; i++) rd_check("R1 reset value", 16'h01E0 + 16'(i), rv[i]);
        check("R1 leds dark after reset", {12'h0, led_o}, 16'h0);

        // R2 write / readback / reserved / out of range
        wr(16'h01E5, 16'hABCD);
        rd_check("R2 readback low byte only", 16'h01E5, 16'h00CD);
        rd_check("R2 below range reads zero", 16'h01DF, 16'h0000);
        rd_check("R2 above range reads zero", 16'h01EA, 16'h0000);
        wr(16'h01EA, 16'h0055);
        rd_check("R2 oor write ignored", 16'h01E9, 16'h0020);
        rd_check("R2 oor write ignored 0", 16'h01E0, 16'h00C5);

        // R6 fast rates: LED0 fast on aneg
        do_reset();
        aneg_busy = 1'b1;
        wr(16'h01E2, 16'h000A);
        wr(16'h01E3, 16'h0000);
        for (int c = 0; c < 4; c++) begin
            wr(16'h01E0, 16'(c << 6));
            measure("R6 fast half period", 0, 250 >> c);
        end
        // R7 slow rates: LED1 slow on aneg
        wr(16'h01E4, 16'h0000);
        wr(16'h01E5, 16'h00A0);
        for (int c = 1; c < 4; c++) begin
            wr(16'h01E0, 16'(c << 4));
            measure("R7 slow half period", 1, 250 >> c);
        end

        // Known phases: fast (16 Hz, 31) high, slow (8 Hz, 62) low
        do_reset();
        wr(16'h01E0, 16'h00E0);
        ticks(31);
        aneg_busy = 1'b0;

        // R8 directed priority on LED0
        aneg_busy = 1'b1;
        wr(16'h01E3, 16'h00A0);
        wr(16'h01E2, 16'h00AA);
        settle(2);
        check("R8 fast wins (fast wave high)", {15'h0, led_o[0]}, 16'h1);
        wr(16'h01E2, 16'h00A0);
        settle(2);
        check("R8 slow over steady (slow wave low)", {15'h0, led_o[0]}, 16'h0);
        wr(16'h01E3, 16'h0000);
        settle(2);
        check("R5 steady when no blink", {15'h0, led_o[0]}, 16'h1);

        // R11 registered output
        @(negedge clk); aneg_busy = 1'b0;
        #1 check("R11 no combinational path", {15'h0, led_o[0]}, 16'h1);
        @(negedge clk);
        check("R11 update after one edge", {15'h0, led_o[0]}, 16'h0);

        // R3 / R4 directed corners on LED0 steady
        link_up = 1'b1; link_speed = 2'd3;
        wr(16'h01E2, 16'h0070); settle(2);
        check("R3 no speed not in set", {15'h0, led_o[0]}, 16'h0);
        link_up = 1'b0; link_speed = 2'd0;
        wr(16'h01E2, 16'h0010); settle(2);
        check("R3 link down false", {15'h0, led_o[0]}, 16'h0);
        link_up = 1'b1; settle(2);
        check("R3 10M in set", {15'h0, led_o[0]}, 16'h1);
        pwr_down = 1; eee_active = 1; aneg_busy = 1; selftest_busy = 1; cdiag_busy = 1;
        for (int c = 13; c < 16; c++) begin
            wr(16'h01E2, 16'(c << 4)); settle(2);
            check("R4 codes D-F never true", {15'h0, led_o[0]}, 16'h0);
        end
        wr(16'h01E2, 16'h0000); settle(2);
        check("R4 code 0 never true", {15'h0, led_o[0]}, 16'h0);
        wr(16'h01E2, 16'h00C0); settle(2);
        check("R4 code C cable diag", {15'h0, led_o[0]}, 16'h1);

        // Random: no ticks, fast=1 slow=0 phases; R3 R4 R5 R8 R10
        for (int it = 0; it < 40; it++) begin
            for (int l = 0; l < 4; l++) begin
                hi[l] = 8'($urandom);
                lo[l] = 8'($urandom) & 8'hF0;
                wr(16'h01E2 + 16'(2*l), {8'h0, hi[l]});
                wr(16'h01E3 + 16'(2*l), {8'h0, lo[l]});
            end
            wr(16'h01E0, 16'h00E0 | 16'($urandom % 8)); // R10 inverse bits
            wr(16'h01E1, 16'($urandom % 256));          // R10 global low
            link_up = 1'($urandom); link_speed = 2'($urandom);
            pwr_down = 1'($urandom); eee_active = 1'($urandom);
            aneg_busy = 1'($urandom); selftest_busy = 1'($urandom);
            cdiag_busy = 1'($urandom);
            settle(3);
            for (int l = 0; l < 4; l++) begin
                e = cond(hi[l][3:0]) ? 1'b1 :
                    cond(lo[l][7:4]) ? 1'b0 : cond(hi[l][7:4]);
                check("R8/R5/R10 random led", {15'h0, led_o[l]}, {15'h0, e});
            end
        end

        // R9 pulse stretch on LED2 (steady only)
        pwr_down = 0; eee_active = 0; aneg_busy = 0; selftest_busy = 0; cdiag_busy = 0;
        link_up = 1'b1; link_speed = 2'd2;
        wr(16'h01E6, 16'h0070);
        wr(16'h01E7, 16'h0001);
        settle(2);
        check("R9 lit before event", {15'h0, led_o[2]}, 16'h1);
        @(negedge clk); tx_act = 1'b1; @(negedge clk); tx_act = 1'b0;
        settle(2);
        check("R9 dark after event", {15'h0, led_o[2]}, 16'h0);
        ticks(29); settle(2);
        check("R9 dark at 29 ticks", {15'h0, led_o[2]}, 16'h0);
        ticks(1); settle(2);
        check("R9 lit at 30 ticks", {15'h0, led_o[2]}, 16'h1);
        @(negedge clk); tx_act = 1'b1; @(negedge clk); tx_act = 1'b0;
        ticks(20);
        @(negedge clk); tx_act = 1'b1; @(negedge clk); tx_act = 1'b0;
        ticks(20); settle(2);
        check("R9 retrigger restarts hold", {15'h0, led_o[2]}, 16'h0);
        ticks(10); settle(2);
        check("R9 lit after restarted hold", {15'h0, led_o[2]}, 16'h1);
        wr(16'h01E7, 16'h000A); // rx + reserved bit3
        @(negedge clk); tx_act = 1'b1; col_det = 1'b1;
        @(negedge clk); tx_act = 1'b0; col_det = 1'b0;
        settle(2);
        check("R9 unmasked events ignored", {15'h0, led_o[2]}, 16'h1);
        @(negedge clk); rx_act = 1'b1; @(negedge clk); rx_act = 1'b0;
        settle(2);
        check("R9 rx masked event darkens", {15'h0, led_o[2]}, 16'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule